// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped watchdog. It compares a free-running 64-bit system count, supplied from outside, against an absolute deadline that it holds itself. Each refresh loads the deadline with the present count plus a 32-bit period. If software lets the deadline pass, the block raises a first warning output, meant to drive an interrupt, and loads a second deadline one period later. If that deadline also passes with no refresh, a second output rises, meant to drive a system reset. With no refresh at all, the time from the last refresh to the reset request is therefore two periods.

Software reaches the block through a simple single-cycle read/write request port. One select bit picks one of two frames. The kick frame has a single refresh location. The control frame holds the control/status word, the period, and the deadline, which software reads as two 32-bit words. Both frames carry two identification words. Two resets come in. The ordinary reset, which the watchdog's own second stage can drive, clears the operating state. The power-on reset also clears a sticky flag, and that flag lets software learn after boot that the watchdog caused the last reset.

Top module: `wdog_dual_stage`

## Requirements
- R1: After reset, the control/status word (control frame, offset 0x000) reads 0 apart from the sticky flag, the period (control frame, 0x008) reads the `RST_OFFSET` parameter, the deadline reads 0, and both stage outputs are low.
- R2: A write of any data to the kick location (kick frame, `req_frame_i`=0, offset 0x000) loads the deadline with count + period and clears both stages.
- R3: A write to the control/status word sets the enable from data bit 0 and counts as a refresh. Bits 1 and 2 of the written data have no effect. On reads, bit 0 is enable, bit 1 is the first-stage flag and bit 2 is the sticky second-stage flag.
- R4: A write to the period (control frame, 0x008) stores the data. It acts as a refresh, using the new period, only while the block is enabled. While the block is disabled it leaves the deadline unchanged.
- R5: While the block is enabled and the first stage is clear, the first clock edge with count >= deadline sets the first stage and reloads the deadline with count + period.
- R6: While the block is enabled and the first stage is set, count >= deadline raises the second stage. So with no refresh, the second stage asserts two periods after the last refresh, and never without the first.
- R7: While enable is 0, neither stage flag can become set, the deadline does not advance on its own, and both outputs stay low.
- R8: The deadline reads as its low word at control offset 0x010 and its high word at 0x014.
- R9: The sticky second-stage flag survives the ordinary reset and clears only on power-on reset. The second-stage output itself is cleared by the ordinary reset and by any refresh.
- R10: Offsets 0xFCC and 0xFD0 return the `ID0_VAL` and `ID1_VAL` parameters in both frames.
- R11: Unmapped offsets read 0, the kick location reads 0, and writes to read-only or unmapped locations change nothing.
- R12: Read data is registered. It appears on `rsp_rdata_o` from the clock edge that accepts the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Ordinary asynchronous active-low reset |
| por_n | input | 1 | Power-on asynchronous active-low reset |
| cnt_i | input | 64 | Free-running system count |
| req_valid_i | input | 1 | Request valid for this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_frame_i | input | 1 | 0 = kick frame, 1 = control frame |
| req_addr_i | input | 12 | Byte offset within the frame |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Registered read data |
| stage1_o | output | 1 | First-stage warning (interrupt) |
| stage2_o | output | 1 | Second-stage request (system reset) |

## Verification
Some properties hold on every cycle, and the assertions check those:
- The second stage never appears without the first.
- The first stage only rises after the count has reached the deadline.
- A kick always leaves both stages clear.
- Nothing escalates while the block is disabled.
- A period write while disabled leaves the deadline alone.
- The sticky flag never drops between power-on resets.

Other behaviour can only be shown by scenarios. The bench drives those:
- The exact two-period escalation timing.
- The deadline value after each kind of refresh.
- The sticky flag's survival across an ordinary reset.
- The identification and unmapped reads in both frames.
- The registered read latency.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 64;
  localparam int unsigned PAD_W  = CNT_W - DATA_W;

  // frame select encoding
  localparam logic FR_KICK    = 1'b0;
  localparam logic FR_CONTROL = 1'b1;

  // byte offsets inside a frame
  localparam logic [ADDR_W-1:0] OFS_KICK  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_PER   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_DLO   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_DHI   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_IDA   = 12'hFCC;
  localparam logic [ADDR_W-1:0] OFS_IDB   = 12'hFD0;

  // status bit positions
  localparam int unsigned ST_EN  = 0;
  localparam int unsigned ST_S1  = 1;
  localparam int unsigned ST_S2  = 2;

  typedef struct packed {
    logic              kick;
    logic              ctl_wr;
    logic              per_wr;
    logic [DATA_W-1:0] wdata;
  } wr_cmd_t;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign srst_n = shift_q[STAGES-1];

endmodule

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID0_VAL = 32'h0,
  parameter logic [DATA_W-1:0] ID1_VAL = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_frame,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              en_q,
  input  logic              s1_q,
  input  logic              stk_q,
  input  logic [DATA_W-1:0] per_q,
  input  logic [CNT_W-1:0]  dl_q,
  output wr_cmd_t           cmd,
  output logic [DATA_W-1:0] rdata
);

  logic              wr_en;
  logic              rd_en;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] status;

  assign wr_en = req_valid &  req_write;
  assign rd_en = req_valid & ~req_write;

  // write decode
  always_comb begin
    cmd.kick   = wr_en && (req_frame == FR_KICK)    && (req_addr == OFS_KICK);
    cmd.ctl_wr = wr_en && (req_frame == FR_CONTROL) && (req_addr == OFS_CTRL);
    cmd.per_wr = wr_en && (req_frame == FR_CONTROL) && (req_addr == OFS_PER);
    cmd.wdata  = req_wdata;
  end

  always_comb begin
    status        = '0;
    status[ST_EN] = en_q;
    status[ST_S1] = s1_q;
    status[ST_S2] = stk_q;
  end

  // read mux
  always_comb begin
    rd_d = '0;
    if (req_addr == OFS_IDA) begin
      rd_d = ID0_VAL;
    end else if (req_addr == OFS_IDB) begin
      rd_d = ID1_VAL;
    end else if (req_frame == FR_CONTROL) begin
      case (req_addr)
        OFS_CTRL: rd_d = status;
        OFS_PER:  rd_d = per_q;
        OFS_DLO:  rd_d = dl_q[DATA_W-1:0];
        OFS_DHI:  rd_d = dl_q[CNT_W-1:DATA_W];
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_OFFSET = 32'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  wr_cmd_t           cmd,
  output logic              en_q,
  output logic              s1_q,
  output logic              s2_q,
  output logic              stk_q,
  output logic [DATA_W-1:0] per_q,
  output logic [CNT_W-1:0]  dl_q
);

  logic              en_d;
  logic              s1_d;
  logic              s2_d;
  logic              stk_set;
  logic [DATA_W-1:0] per_d;
  logic [CNT_W-1:0]  dl_d;
  logic              refresh;
  logic              reached;
  logic [CNT_W-1:0]  next_dl;

  assign refresh = cmd.kick | cmd.ctl_wr | (cmd.per_wr & en_q);
  assign reached = en_q && (cnt >= dl_q);
  assign next_dl = cnt + {{PAD_W{1'b0}}, per_d};

  always_comb begin
    en_d    = en_q;
    s1_d    = s1_q;
    s2_d    = s2_q;
    per_d   = per_q;
    dl_d    = dl_q;
    stk_set = 1'b0;
    if (cmd.per_wr) begin
      per_d = cmd.wdata;
    end
    if (cmd.ctl_wr) begin
      en_d = cmd.wdata[ST_EN];
    end
    if (refresh) begin
      dl_d = next_dl;
      s1_d = 1'b0;
      s2_d = 1'b0;
    end else if (reached) begin
      if (!s1_q) begin
        s1_d = 1'b1;
        dl_d = next_dl;
      end else begin
        s2_d    = 1'b1;
        stk_set = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      per_q <= RST_OFFSET;
      dl_q  <= '0;
    end else begin
      en_q  <= en_d;
      s1_q  <= s1_d;
      s2_q  <= s2_d;
      per_q <= per_d;
      dl_q  <= dl_d;
    end
  end

  // sticky flag lives in the power-on domain
  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) begin
      stk_q <= 1'b0;
    end else if (stk_set) begin
      stk_q <= 1'b1;
    end
  end

endmodule

// File: rtl/wdog_dual_stage.sv
module wdog_dual_stage
  import wdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID0_VAL     = 32'h5744_0101,
  parameter logic [DATA_W-1:0] ID1_VAL     = 32'h0000_A5C3,
  parameter logic [DATA_W-1:0] RST_OFFSET  = 32'h0000_0100,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [63:0]       cnt_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_frame_i,
  input  logic [11:0]       req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic [31:0]       rsp_rdata_o,
  output logic              stage1_o,
  output logic              stage2_o
);

  logic              core_rst_n;
  logic              por_rst_n;
  logic              sys_arst_n;
  wr_cmd_t           cmd;
  logic              en_q;
  logic              s1_q;
  logic              s2_q;
  logic              stk_q;
  logic [DATA_W-1:0] per_q;
  logic [CNT_W-1:0]  dl_q;

  assign sys_arst_n = rst_n & por_n;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_sys (
    .clk    (clk),
    .arst_n (sys_arst_n),
    .srst_n (core_rst_n)
  );

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_por (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (por_rst_n)
  );

  wdog_regif #(.ID0_VAL(ID0_VAL), .ID1_VAL(ID1_VAL)) u_regif (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .req_valid (req_valid_i),
    .req_write (req_write_i),
    .req_frame (req_frame_i),
    .req_addr  (req_addr_i),
    .req_wdata (req_wdata_i),
    .en_q      (en_q),
    .s1_q      (s1_q),
    .stk_q     (stk_q),
    .per_q     (per_q),
    .dl_q      (dl_q),
    .cmd       (cmd),
    .rdata     (rsp_rdata_o)
  );

  wdog_core #(.RST_OFFSET(RST_OFFSET)) u_core (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .por_rst_n (por_rst_n),
    .cnt       (cnt_i),
    .cmd       (cmd),
    .en_q      (en_q),
    .s1_q      (s1_q),
    .s2_q      (s2_q),
    .stk_q     (stk_q),
    .per_q     (per_q),
    .dl_q      (dl_q)
  );

  assign stage1_o = en_q & s1_q;
  assign stage2_o = en_q & s2_q;

endmodule

// File: rtl/wdog_dual_stage_chk.sv
module wdog_dual_stage_chk (
  input logic        clk,
  input logic        core_rst_n,
  input logic        por_rst_n,
  input logic        req_valid_i,
  input logic        req_write_i,
  input logic        req_frame_i,
  input logic [11:0] req_addr_i,
  input logic [63:0] cnt_i,
  input logic        en_q,
  input logic        s1_q,
  input logic        s2_q,
  input logic        stk_q,
  input logic [63:0] dl_q,
  input logic        stage1_o,
  input logic        stage2_o
);

  // R6
  stage2_needs_stage1_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    stage2_o |-> stage1_o);

  // R5
  stage1_after_deadline_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(s1_q) |-> $past(cnt_i >= dl_q));

  // R2
  kick_clears_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (req_valid_i && req_write_i && !req_frame_i && req_addr_i == 12'h000)
      |=> (!s1_q && !s2_q));

  // R7
  no_escalate_disabled_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !en_q |=> (!$rose(s1_q) && !$rose(s2_q)));

  // R4
  period_wr_disabled_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!en_q && req_valid_i && req_write_i && req_frame_i && req_addr_i == 12'h008)
      |=> $stable(dl_q));

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
    stk_q |=> stk_q);

endmodule

bind wdog_dual_stage wdog_dual_stage_chk u_chk (
  .clk         (clk),
  .core_rst_n  (core_rst_n),
  .por_rst_n   (por_rst_n),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_frame_i (req_frame_i),
  .req_addr_i  (req_addr_i),
  .cnt_i       (cnt_i),
  .en_q        (en_q),
  .s1_q        (s1_q),
  .s2_q        (s2_q),
  .stk_q       (stk_q),
  .dl_q        (dl_q),
  .stage1_o    (stage1_o),
  .stage2_o    (stage2_o)
);

// File: tb/wdog_dual_stage_tb_top.sv
`timescale 1ns/1ps
module wdog_dual_stage_tb_top;

  localparam logic [31:0] ID0 = 32'h5744_0101;
  localparam logic [31:0] ID1 = 32'h0000_A5C3;
  localparam logic [31:0] RST_OFF = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n, por_n;
  logic [63:0] cnt_i;
  logic        req_valid_i, req_write_i, req_frame_i;
  logic [11:0] req_addr_i;
  logic [31:0] req_wdata_i;
  logic [31:0] rsp_rdata_o;
  logic        stage1_o, stage2_o;

  always #2 clk = ~clk;

  wdog_dual_stage #(.ID0_VAL(ID0), .ID1_VAL(ID1), .RST_OFFSET(RST_OFF)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .cnt_i(cnt_i),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_frame_i(req_frame_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .rsp_rdata_o(rsp_rdata_o),
    .stage1_o(stage1_o), .stage2_o(stage2_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic        m_en, m_s1, m_s2, m_stk;
  logic [31:0] m_per;
  logic [63:0] m_dl;
  logic [63:0] b_cnt = 64'd1000;
  logic [31:0] last_rd;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic f, input logic [11:0] a);
    if (a == 12'hFCC) return ID0;
    if (a == 12'hFD0) return ID1;
    if (!f) return 32'h0;
    case (a)
      12'h000: return {29'h0, m_stk, m_s1, m_en};
      12'h008: return m_per;
      12'h010: return m_dl[31:0];
      12'h014: return m_dl[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_step(input logic v, input logic w, input logic f, input logic [11:0] a,
                        input logic [31:0] d, input logic [63:0] c);
    logic kick, ctl, per, refr;
    logic [31:0] per_n;
    kick = v && w && !f && a == 12'h000;
    ctl  = v && w &&  f && a == 12'h000;
    per  = v && w &&  f && a == 12'h008;
    per_n = per ? d : m_per;
    refr = kick || ctl || (per && m_en);
    if (refr) begin
      m_dl = c + {32'h0, per_n};
      m_s1 = 1'b0;
      m_s2 = 1'b0;
    end else if (m_en && c >= m_dl) begin
      if (!m_s1) begin
        m_s1 = 1'b1;
        m_dl = c + {32'h0, per_n};
      end else begin
        m_s2  = 1'b1;
        m_stk = 1'b1;
      end
    end
    if (ctl) m_en = d[0];
    m_per = per_n;
  endtask

  task automatic cyc(input logic v, input logic w, input logic f, input logic [11:0] a,
                     input logic [31:0] d, input string tag);
    logic [31:0] exp_rd;
    logic [63:0] c;
    @(negedge clk);
    c = b_cnt;
    req_valid_i = v; req_write_i = w; req_frame_i = f; req_addr_i = a; req_wdata_i = d;
    cnt_i = c;
    @(posedge clk);
    #1;
    exp_rd = m_read(f, a);
    m_step(v, w, f, a, d, c);
    b_cnt = b_cnt + 64'd1;
    chk({tag, " stage outputs"}, {62'h0, stage1_o, stage2_o}, {62'h0, m_en & m_s1, m_en & m_s2});
    if (v && !w) begin
      chk({tag, " read data"}, {32'h0, rsp_rdata_o}, {32'h0, exp_rd});
      last_rd = rsp_rdata_o;
    end
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 1'b0, 12'h0, 32'h0, tag);
  endtask

  task automatic rd(input logic f, input logic [11:0] a, input string tag);
    cyc(1'b1, 1'b0, f, a, 32'h0, tag);
  endtask

  task automatic wr(input logic f, input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, f, a, d, tag);
  endtask

  task automatic do_rst(input bit por);
    @(negedge clk);
    req_valid_i = 1'b0;
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
    m_en = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0; m_per = RST_OFF; m_dl = 64'h0;
    if (por) m_stk = 1'b0;
    repeat (4) idle("R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual run still active, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int first1, first2;
    logic [31:0] hold;
    logic [63:0] c0;
    logic [11:0] addrs [8];
    void'($urandom(32'd4242));
    addrs[0] = 12'h000; addrs[1] = 12'h008; addrs[2] = 12'h010; addrs[3] = 12'h014;
    addrs[4] = 12'hFCC; addrs[5] = 12'hFD0; addrs[6] = 12'h004; addrs[7] = 12'h018;
    rst_n = 1'b0; por_n = 1'b0; cnt_i = 64'h0;
    req_valid_i = 1'b0; req_write_i = 1'b0; req_frame_i = 1'b0;
    req_addr_i = 12'h0; req_wdata_i = 32'h0; m_stk = 1'b0;
    do_rst(1'b1);

    // R1 reset values
    rd(1'b1, 12'h000, "R1"); chk("R1 status", {32'h0, last_rd}, 64'h0);
    rd(1'b1, 12'h008, "R1"); chk("R1 period", {32'h0, last_rd}, {32'h0, RST_OFF});
    rd(1'b1, 12'h010, "R1"); chk("R1 deadline", {32'h0, last_rd}, 64'h0);

    // R10 identification in both frames
    rd(1'b0, 12'hFCC, "R10"); chk("R10 kick id0", {32'h0, last_rd}, {32'h0, ID0});
    rd(1'b0, 12'hFD0, "R10"); chk("R10 kick id1", {32'h0, last_rd}, {32'h0, ID1});
    rd(1'b1, 12'hFCC, "R10"); chk("R10 ctl id0", {32'h0, last_rd}, {32'h0, ID0});
    rd(1'b1, 12'hFD0, "R10"); chk("R10 ctl id1", {32'h0, last_rd}, {32'h0, ID1});

    // R11 unmapped and read-only
    rd(1'b1, 12'h004, "R11"); chk("R11 unmapped", {32'h0, last_rd}, 64'h0);
    rd(1'b0, 12'h008, "R11"); chk("R11 kick frame 0x008", {32'h0, last_rd}, 64'h0);
    wr(1'b1, 12'h010, 32'hDEAD_BEEF, "R11");
    rd(1'b1, 12'h010, "R11"); chk("R11 ro deadline", {32'h0, last_rd}, 64'h0);
    rd(1'b0, 12'h000, "R11"); chk("R11 kick reads 0", {32'h0, last_rd}, 64'h0);

    // R4 period write while disabled keeps deadline; R12 read latency/hold
    wr(1'b1, 12'h008, 32'd10, "R4");
    rd(1'b1, 12'h008, "R12"); chk("R12 period readback", {32'h0, last_rd}, 64'd10);
    idle("R12"); chk("R12 hold", {32'h0, rsp_rdata_o}, 64'd10);
    rd(1'b1, 12'h010, "R4"); chk("R4 deadline frozen", {32'h0, last_rd}, 64'h0);

    // R3 enable write, bits 1/2 ignored, acts as refresh
    c0 = b_cnt;
    wr(1'b1, 12'h000, 32'h7, "R3");
    rd(1'b1, 12'h000, "R3"); chk("R3 status", {32'h0, last_rd}, 64'h1);
    rd(1'b1, 12'h010, "R8"); chk("R8 deadline lo", {32'h0, last_rd}, {32'h0, c0[31:0] + 32'd10});
    rd(1'b1, 12'h014, "R8"); chk("R8 deadline hi", {32'h0, last_rd}, {32'h0, c0[63:32]});

    // R5/R6 escalation timing from a kick
    c0 = b_cnt;
    wr(1'b0, 12'h000, 32'h1234_5678, "R2");
    first1 = -1; first2 = -1;
    for (int i = 1; i <= 30; i++) begin
      idle("R6");
      if (stage1_o && first1 < 0) first1 = i;
      if (stage2_o && first2 < 0) first2 = i;
    end
    chk("R5 stage1 delay", first1, 10);
    chk("R6 stage2 delay", first2, 20);

    // R2 kick clears stages
    wr(1'b0, 12'h000, 32'hFFFF_FFFF, "R2");
    chk("R2 stages clear", {62'h0, stage1_o, stage2_o}, 64'h0);

    // R9 sticky survives ordinary reset
    repeat (25) idle("R6");
    chk("R9 stage2 before reset", {63'h0, stage2_o}, 64'h1);
    do_rst(1'b0);
    chk("R9 stage2 after reset", {63'h0, stage2_o}, 64'h0);
    rd(1'b1, 12'h000, "R9"); chk("R9 sticky kept", {32'h0, last_rd}, 64'h4);
    do_rst(1'b1);
    rd(1'b1, 12'h000, "R9"); chk("R9 sticky cleared", {32'h0, last_rd}, 64'h0);

    // R7 disabled: huge count, nothing escalates
    wr(1'b1, 12'h008, 32'd3, "R7");
    b_cnt = 64'hFFFF_0000_0000_0000;
    repeat (10) idle("R7");
    chk("R7 outputs low", {62'h0, stage1_o, stage2_o}, 64'h0);
    rd(1'b1, 12'h000, "R7"); chk("R7 status", {32'h0, last_rd}, 64'h0);
    b_cnt = 64'd5000;

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = int'($urandom % 16);
      b_cnt = b_cnt + 64'($urandom % 3);
      case (r)
        8, 9:  rd(1'($urandom), addrs[$urandom % 8], "R11");
        10:    wr(1'b0, 12'h000, $urandom, "R2");
        11:    wr(1'b1, 12'h000, $urandom, "R3");
        12:    wr(1'b1, 12'h008, $urandom % 24, "R4");
        13:    wr(1'($urandom), addrs[$urandom % 8], $urandom % 24, "R11");
        14:    if ($urandom % 60 == 0) do_rst(bit'($urandom % 2)); else idle("R5");
        default: idle("R6");
      endcase
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule